// File: doc/BRIEF.md
# Audio Frame DMA and Doorbell Sequencer

This block sits between a PCM-style sample port and a processing core. Every strobe on the incoming side copies the single PCM input sample into the next word of a two-half input bank. When one half holds a whole frame, a level doorbell tells the core which half is ready. Capture then carries on into the other half, so the next frame is collected while the current one is processed. The core acknowledges the doorbell, reads its frame through a core-side memory port, and writes its results into a matching half of an output bank. It then pulses a done line. The block forwards that pulse to the control side as a completion interrupt and plays the finished half back through the single PCM output register, one sample per outgoing strobe.

Each bank is a dual-port RAM. The DMA side owns one port and the core-side interface owns the other. Two state machines pace the work. The doorbell machine has the states DB_IDLE, DB_RING (doorbell raised) and DB_BUSY (acknowledged, core working). Its transitions are:
- DB_IDLE to DB_RING when a frame completes.
- DB_RING to DB_RING when a frame completes again. This replaces the offered half.
- DB_RING to DB_BUSY on an acknowledge.
- DB_BUSY to DB_RING when a frame completes.
- DB_BUSY to DB_IDLE when the core reports done.

The playback machine has the states PB_IDLE and PB_PLAY. It moves from PB_IDLE to PB_PLAY when a finished half arrives. It moves from PB_PLAY back to PB_IDLE when the last sample of a frame goes out and no other finished half is waiting. Otherwise it stays in PB_PLAY and moves to the waiting half.

Top module: `audio_frame_dma`

## Requirements
- R1: After reset, start_irq, done_irq, overrun and underrun are 0, pcm_out_data is 0, and capture starts at index 0 of half 0.
- R2: Each pcm_in_strobe stores pcm_in_data at core address IN_BASE + half*FRAME_LEN + index. The index runs from 0 to FRAME_LEN-1, and the half toggles after each full frame. The core reads that word back combinationally on core_rdata. Core reads outside the input window return 0, and core writes there are ignored.
- R3: When the FRAME_LEN-th sample of a half is stored, start_irq is high from the next cycle, and start_half (0 or 1) names the half just filled.
- R4: start_irq stays high until start_ack is seen while it is high. It is low from the following cycle, unless a frame completes in that same cycle.
- R5: When a frame completes while start_irq is high and start_ack is low, overrun becomes 1 and stays 1 until reset. start_half then names the newest half. A completion in the same cycle as an acknowledge does not set overrun.
- R6: Core writes with core_we high at address OUT_BASE + h*FRAME_LEN + i store into output half h, sample i. Every one-cycle core_done pulse gives a one-cycle done_irq pulse in the next cycle.
- R7: core_done makes the half that was last acknowledged ready for playback. Each pcm_out_strobe then loads that half's samples into pcm_out_data in index order 0 to FRAME_LEN-1. The value is visible from the next cycle and held between strobes.
- R8: One finished half may wait behind the half being played. A further core_done while one is waiting replaces the waiting half.
- R9: A pcm_out_strobe with no finished half available loads 0 into pcm_out_data and sets underrun, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pcm_in_strobe | input | 1 | Incoming sample strobe, one cycle |
| pcm_in_data | input | DATA_W | PCM input sample register |
| pcm_out_strobe | input | 1 | Outgoing sample strobe, one cycle |
| pcm_out_data | output | DATA_W | PCM output sample register |
| start_irq | output | 1 | Doorbell to the core, level |
| start_half | output | 1 | Input half offered by the doorbell |
| start_ack | input | 1 | Core acknowledge of the doorbell |
| core_done | input | 1 | Core finished a frame, one-cycle pulse |
| done_irq | output | 1 | Completion interrupt to the control side, one-cycle pulse |
| core_addr | input | ADDR_W | Core-side memory address |
| core_we | input | 1 | Core-side write enable |
| core_wdata | input | DATA_W | Core-side write data |
| core_rdata | output | DATA_W | Core-side read data, combinational |
| overrun | output | 1 | Sticky: a frame completed with the doorbell unacknowledged |
| underrun | output | 1 | Sticky: output strobe found nothing to play |

## Verification
A wrong capture index or half shows at the core port as a mismatched read on the very frame it happens. It also shows as start_irq rising one sample early or late, on the cycle after the faulty store. A corrupted doorbell state shows at start_irq or overrun within one cycle of the next acknowledge or frame completion. A wrong playback index or queue entry shows on pcm_out_data on the cycle after the next outgoing strobe. A bench model that predicts every output on every clock therefore catches such faults no later than the next strobe that touches them.

// File: rtl/afd_pkg.sv
package afd_pkg;
    typedef enum logic [1:0] {
        DB_IDLE = 2'd0,
        DB_RING = 2'd1,
        DB_BUSY = 2'd2
    } db_state_t;

    typedef enum logic {
        PB_IDLE = 1'b0,
        PB_PLAY = 1'b1
    } pb_state_t;
endpackage

// File: rtl/afd_ram.sv
// One write port, one combinational read port; each side of the bank
// belongs to a different agent.
module afd_ram #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 32,
    parameter int unsigned AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/afd_capture.sv
// Input-side address counter: sample index plus half select.
module afd_capture #(
    parameter int unsigned FRAME_LEN = 16,
    parameter int unsigned IDX_W     = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    output logic [IDX_W-1:0] idx,
    output logic             half,
    output logic             frame_done
);
    logic at_last;

    assign at_last    = (idx == IDX_W'(FRAME_LEN - 1));
    assign frame_done = strobe && at_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx  <= '0;
            half <= 1'b0;
        end else if (strobe) begin
            if (at_last) begin
                idx  <= '0;
                half <= ~half;
            end else begin
                idx  <= idx + IDX_W'(1);
            end
        end
    end
endmodule

// File: rtl/afd_doorbell.sv
// Frame-level handshake with the processing core.
module afd_doorbell
    import afd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_done,
    input  logic frame_half,
    input  logic start_ack,
    input  logic core_done,
    output logic start_irq,
    output logic start_half,
    output logic busy_half,
    output logic done_irq,
    output logic overrun
);
    db_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= DB_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            DB_IDLE: if (frame_done) state_nx = DB_RING;
            DB_RING: begin
                if (frame_done)     state_nx = DB_RING;
                else if (start_ack) state_nx = DB_BUSY;
            end
            DB_BUSY: begin
                if (frame_done)     state_nx = DB_RING;
                else if (core_done) state_nx = DB_IDLE;
            end
            default: state_nx = DB_IDLE;
        endcase
    end

    assign start_irq = (state == DB_RING);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_half <= 1'b0;
            busy_half  <= 1'b0;
            done_irq   <= 1'b0;
            overrun    <= 1'b0;
        end else begin
            done_irq <= core_done;
            if (frame_done) begin
                start_half <= frame_half;
            end
            if (state == DB_RING && start_ack) begin
                busy_half <= start_half;
            end
            if (state == DB_RING && frame_done && !start_ack) begin
                overrun <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/afd_playback.sv
// Output-side sequencer: one half playing, one half waiting.
module afd_playback
    import afd_pkg::*;
#(
    parameter int unsigned FRAME_LEN = 16,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned IDX_W     = $clog2(FRAME_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              load_half,
    input  logic              strobe,
    input  logic [DATA_W-1:0] rd_data,
    output logic              rd_half,
    output logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] pcm_out_data,
    output logic              underrun
);
    pb_state_t state, state_nx;
    logic      nxt_valid, nxt_half;
    logic      at_last;

    assign at_last = (rd_idx == IDX_W'(FRAME_LEN - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PB_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            PB_IDLE: if (load) state_nx = PB_PLAY;
            PB_PLAY: if (strobe && at_last && !nxt_valid && !load) state_nx = PB_IDLE;
            default: state_nx = PB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcm_out_data <= '0;
            underrun     <= 1'b0;
            rd_idx       <= '0;
            rd_half      <= 1'b0;
            nxt_valid    <= 1'b0;
            nxt_half     <= 1'b0;
        end else begin
            if (strobe) begin
                if (state == PB_PLAY) begin
                    pcm_out_data <= rd_data;
                    rd_idx       <= at_last ? '0 : rd_idx + IDX_W'(1);
                end else begin
                    pcm_out_data <= '0;
                    underrun     <= 1'b1;
                end
            end
            if (state == PB_IDLE) begin
                if (load) rd_half <= load_half;
            end else if (strobe && at_last) begin
                if (nxt_valid) begin
                    rd_half   <= nxt_half;
                    nxt_valid <= load;
                    if (load) nxt_half <= load_half;
                end else if (load) begin
                    rd_half <= load_half;
                end
            end else if (load) begin
                nxt_valid <= 1'b1;
                nxt_half  <= load_half;
            end
        end
    end
endmodule

// File: rtl/audio_frame_dma.sv
module audio_frame_dma #(
    parameter int unsigned       FRAME_LEN = 16,
    parameter int unsigned       DATA_W    = 32,
    parameter int unsigned       ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] IN_BASE   = 8'h00,
    parameter logic [ADDR_W-1:0] OUT_BASE  = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pcm_in_strobe,
    input  logic [DATA_W-1:0] pcm_in_data,
    input  logic              pcm_out_strobe,
    output logic [DATA_W-1:0] pcm_out_data,
    output logic              start_irq,
    output logic              start_half,
    input  logic              start_ack,
    input  logic              core_done,
    output logic              done_irq,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic              core_we,
    input  logic [DATA_W-1:0] core_wdata,
    output logic [DATA_W-1:0] core_rdata,
    output logic              overrun,
    output logic              underrun
);
    localparam int unsigned IDX_W      = $clog2(FRAME_LEN);
    localparam int unsigned BANK_DEPTH = 2 * FRAME_LEN;
    localparam int unsigned BANK_AW    = $clog2(BANK_DEPTH);

    logic [IDX_W-1:0]   cap_idx, pb_idx;
    logic               cap_half, frame_done, busy_half, pb_half;
    logic [BANK_AW-1:0] cap_addr, pb_addr;
    logic [ADDR_W-1:0]  in_off, out_off;
    logic               in_hit, out_hit;
    logic [DATA_W-1:0]  in_rd, out_rd;

    assign in_off   = core_addr - IN_BASE;
    assign out_off  = core_addr - OUT_BASE;
    assign in_hit   = (in_off < ADDR_W'(BANK_DEPTH));
    assign out_hit  = (out_off < ADDR_W'(BANK_DEPTH));
    assign core_rdata = in_hit ? in_rd : '0;

    assign cap_addr = cap_half ? BANK_AW'(FRAME_LEN) + BANK_AW'(cap_idx) : BANK_AW'(cap_idx);
    assign pb_addr  = pb_half  ? BANK_AW'(FRAME_LEN) + BANK_AW'(pb_idx)  : BANK_AW'(pb_idx);

    afd_capture #(.FRAME_LEN(FRAME_LEN)) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe     (pcm_in_strobe),
        .idx        (cap_idx),
        .half       (cap_half),
        .frame_done (frame_done)
    );

    afd_ram #(.DATA_W(DATA_W), .DEPTH(BANK_DEPTH)) u_in_bank (
        .clk     (clk),
        .wr_en   (pcm_in_strobe),
        .wr_addr (cap_addr),
        .wr_data (pcm_in_data),
        .rd_addr (in_off[BANK_AW-1:0]),
        .rd_data (in_rd)
    );

    afd_ram #(.DATA_W(DATA_W), .DEPTH(BANK_DEPTH)) u_out_bank (
        .clk     (clk),
        .wr_en   (core_we && out_hit),
        .wr_addr (out_off[BANK_AW-1:0]),
        .wr_data (core_wdata),
        .rd_addr (pb_addr),
        .rd_data (out_rd)
    );

    afd_doorbell u_doorbell (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .frame_half (cap_half),
        .start_ack  (start_ack),
        .core_done  (core_done),
        .start_irq  (start_irq),
        .start_half (start_half),
        .busy_half  (busy_half),
        .done_irq   (done_irq),
        .overrun    (overrun)
    );

    afd_playback #(.FRAME_LEN(FRAME_LEN), .DATA_W(DATA_W)) u_playback (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (core_done),
        .load_half    (busy_half),
        .strobe       (pcm_out_strobe),
        .rd_data      (out_rd),
        .rd_half      (pb_half),
        .rd_idx       (pb_idx),
        .pcm_out_data (pcm_out_data),
        .underrun     (underrun)
    );
endmodule

// File: rtl/afd_checker.sv
module afd_checker #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pcm_in_strobe,
    input logic              pcm_out_strobe,
    input logic              start_ack,
    input logic              core_done,
    input logic              start_irq,
    input logic              start_half,
    input logic              done_irq,
    input logic [DATA_W-1:0] pcm_out_data,
    input logic              overrun,
    input logic              underrun
);
    p_no_ring_without_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_irq && !pcm_in_strobe) |=> !start_irq);

    p_ring_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_irq && !start_ack) |=> start_irq);

    p_half_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !pcm_in_strobe |=> $stable(start_half));

    p_overrun_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    p_done_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        core_done |=> done_irq);

    p_done_needs_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !core_done |=> !done_irq);

    p_out_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !pcm_out_strobe |=> $stable(pcm_out_data));

    p_underrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun);
endmodule

bind audio_frame_dma afd_checker #(.DATA_W(DATA_W)) u_afd_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .pcm_in_strobe  (pcm_in_strobe),
    .pcm_out_strobe (pcm_out_strobe),
    .start_ack      (start_ack),
    .core_done      (core_done),
    .start_irq      (start_irq),
    .start_half     (start_half),
    .done_irq       (done_irq),
    .pcm_out_data   (pcm_out_data),
    .overrun        (overrun),
    .underrun       (underrun)
);

// File: tb/audio_frame_dma_bench.sv
`timescale 1ns/1ps
module audio_frame_dma_bench;
    localparam int FL = 16;
    localparam int DW = 32;
    localparam logic [7:0] IN_B  = 8'h00;
    localparam logic [7:0] OUT_B = 8'h40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pcm_in_strobe = 1'b0;
    logic [DW-1:0] pcm_in_data = '0;
    logic          pcm_out_strobe = 1'b0;
    logic [DW-1:0] pcm_out_data;
    logic          start_irq, start_half, done_irq, overrun, underrun;
    logic          start_ack = 1'b0;
    logic          core_done = 1'b0;
    logic [7:0]    core_addr = '0;
    logic          core_we = 1'b0;
    logic [DW-1:0] core_wdata = '0;
    logic [DW-1:0] core_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit cmp_en   = 1'b0;
    int seq      = 0;

    always #10 clk = ~clk;

    audio_frame_dma u_audio_frame_dma (
        .clk(clk), .rst_n(rst_n),
        .pcm_in_strobe(pcm_in_strobe), .pcm_in_data(pcm_in_data),
        .pcm_out_strobe(pcm_out_strobe), .pcm_out_data(pcm_out_data),
        .start_irq(start_irq), .start_half(start_half), .start_ack(start_ack),
        .core_done(core_done), .done_irq(done_irq),
        .core_addr(core_addr), .core_we(core_we), .core_wdata(core_wdata),
        .core_rdata(core_rdata), .overrun(overrun), .underrun(underrun)
    );

    // Behavioural reference model
    logic [DW-1:0] m_in  [2*FL];
    logic [DW-1:0] m_out [2*FL];
    int  m_idx, m_half, m_sh, m_bh, m_pidx;
    bit  m_ring, m_done, m_ovr, m_und;
    logic [DW-1:0] m_pcm;
    int  m_q[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_idx = 0; m_half = 0; m_sh = 0; m_bh = 0; m_pidx = 0;
            m_ring = 0; m_done = 0; m_ovr = 0; m_und = 0; m_pcm = '0;
            m_q.delete();
        end else begin
            int  old_sh, old_bh, fh;
            bit  old_ring, fc;
            old_sh = m_sh; old_bh = m_bh; old_ring = m_ring;
            fc = 0; fh = m_half;
            if (pcm_in_strobe) begin
                m_in[m_half*FL + m_idx] = pcm_in_data;
                if (m_idx == FL-1) begin
                    fc = 1; m_idx = 0; m_half = 1 - m_half;
                end else begin
                    m_idx++;
                end
            end
            if (old_ring && start_ack) m_bh = old_sh;
            if (fc) begin
                if (old_ring && !start_ack) m_ovr = 1;
                m_ring = 1; m_sh = fh;
            end else if (old_ring && start_ack) begin
                m_ring = 0;
            end
            m_done = core_done;
            if (pcm_out_strobe) begin
                if (m_q.size() > 0) begin
                    m_pcm = m_out[m_q[0]*FL + m_pidx];
                    m_pidx++;
                    if (m_pidx == FL) begin
                        m_pidx = 0;
                        void'(m_q.pop_front());
                    end
                end else begin
                    m_pcm = '0; m_und = 1;
                end
            end
            if (core_done) begin
                if (m_q.size() < 2) m_q.push_back(old_bh);
                else m_q[1] = old_bh;
            end
            if (core_we && core_addr >= OUT_B && core_addr < OUT_B + 8'(2*FL))
                m_out[core_addr - OUT_B] = core_wdata;
        end
    end

    task automatic check(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && cmp_en) begin
            check(start_irq == m_ring, "R4 start_irq", DW'(start_irq), DW'(m_ring));
            check(start_half == m_sh[0], "R3 start_half", DW'(start_half), DW'(m_sh));
            check(done_irq == m_done, "R6 done_irq", DW'(done_irq), DW'(m_done));
            check(pcm_out_data === m_pcm, "R7 pcm_out_data", pcm_out_data, m_pcm);
            check(overrun == m_ovr, "R5 overrun", DW'(overrun), DW'(m_ovr));
            check(underrun == m_und, "R9 underrun", DW'(underrun), DW'(m_und));
        end
    end

    task automatic do_reset();
        @(negedge clk);
        cmp_en = 0; rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        cmp_en = 1;
    endtask

    task automatic feed(int frames, int period);
        for (int n = 0; n < frames * FL; n++) begin
            @(negedge clk);
            pcm_in_strobe = 1; pcm_in_data = 32'h1000_0000 + DW'(seq * 7); seq++;
            @(negedge clk);
            pcm_in_strobe = 0;
            repeat (period - 2) @(negedge clk);
        end
    endtask

    task automatic serve(int frames);
        for (int f = 0; f < frames; f++) begin
            int h;
            @(negedge clk);
            while (!start_irq) @(negedge clk);
            h = int'(start_half);
            start_ack = 1;
            @(negedge clk);
            start_ack = 0;
            for (int i = 0; i < FL; i++) begin
                core_addr = IN_B + 8'(h*FL + i);
                #2;
                check(core_rdata === m_in[h*FL + i], "R2 core read", core_rdata, m_in[h*FL + i]);
                @(negedge clk);
            end
            for (int i = 0; i < FL; i++) begin
                core_we = 1; core_addr = OUT_B + 8'(h*FL + i);
                core_wdata = (m_in[h*FL + i] ^ 32'hA5A5_0000) + DW'(i);
                @(negedge clk);
            end
            core_we = 0; core_done = 1;
            @(negedge clk);
            core_done = 0;
        end
    endtask

    task automatic drain(int count, int period);
        for (int n = 0; n < count; n++) begin
            @(negedge clk);
            pcm_out_strobe = 1;
            @(negedge clk);
            pcm_out_strobe = 0;
            repeat (period - 2) @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        do_reset();
        // R1 reset state
        check(start_irq == 0, "R1 start_irq", DW'(start_irq), 0);
        check(done_irq == 0, "R1 done_irq", DW'(done_irq), 0);
        check(pcm_out_data == 0, "R1 pcm_out_data", pcm_out_data, 0);
        check(overrun == 0, "R1 overrun", DW'(overrun), 0);
        check(underrun == 0, "R1 underrun", DW'(underrun), 0);

        // R9 strobe with nothing ready
        drain(2, 3);
        @(negedge clk);
        check(underrun == 1, "R9 underrun set", DW'(underrun), 1);
        check(pcm_out_data == 0, "R9 zero sample", pcm_out_data, 0);
        do_reset();
        check(underrun == 0, "R1 underrun cleared", DW'(underrun), 0);

        // Main flow: capture overlaps processing and playback
        fork
            feed(3, 4);
            serve(3);
            begin
                @(negedge clk);
                while (!done_irq) @(negedge clk);
                drain(3 * FL, 5);
            end
        join
        check(overrun == 0, "R5 no overrun with prompt ack", DW'(overrun), 0);

        // R8: three frames finish with no playback; third replaces the waiting one
        fork
            feed(3, 4);
            serve(3);
        join
        drain(FL, 3);
        check(pcm_out_data === m_pcm, "R8 first queued frame", pcm_out_data, m_pcm);
        drain(FL, 3);
        check(pcm_out_data === m_pcm, "R8 replacing frame", pcm_out_data, m_pcm);

        // R5: two frames with no acknowledge
        feed(2, 3);
        @(negedge clk);
        check(overrun == 1, "R5 overrun set", DW'(overrun), 1);
        check(start_half == 1'b1, "R5 newest half offered", DW'(start_half), 1);
        check(start_irq == 1, "R4 still ringing", DW'(start_irq), 1);
        serve(1);
        repeat (2) @(negedge clk);
        check(start_irq == 0, "R4 cleared after ack", DW'(start_irq), 0);
        check(overrun == 1, "R5 overrun sticky", DW'(overrun), 1);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule